// File: doc/BRIEF.md
# CAN Bit Timing and Resynchronization Unit

This block divides the system clock into time quanta and steps each CAN bit through three phases: a one-quantum sync phase, a first phase segment and a second phase segment. At the boundary between the two phase segments it raises a one-cycle sample strobe and captures the received bus level. At the start of every bit it raises a one-cycle transmit-point strobe. All segment lengths come from one 32-bit timing word. Each field in that word holds its length minus one.

The received level passes through a two-flop synchronizer before edge detection. A recessive-to-dominant transition (1 to 0) is treated as a bit edge. When hard sync is disabled, an edge that arrives late (in the first phase segment) stretches that segment. An edge that arrives early (in the second phase segment) trims that segment. The size of either correction is capped by a programmable jump width of 1 to 4 quanta. When hard sync is enabled, an edge restarts the bit at its sync phase. Only one correction of either kind is accepted per bit. The timing word must stay constant while bits are being timed.

Top module: `can_bit_timer`

## Requirements
- R1: One time quantum lasts (P+1) clock cycles, where P is timing word bits [9:0].
- R2: With no edges, a bit lasts 1 + (A+1) + (B+1) quanta, where A is timing word bits [19:16] and B is bits [22:20]. `tx_point` pulses once per bit, in the first cycle of the bit, and `seg_state` reads 0 (sync) in that cycle.
- R3: `sample_strobe` pulses (A+2) quanta after `tx_point` and (B+1) quanta before the next `tx_point`. In that cycle `seg_state` reads 2 (second segment).
- R4: The jump width J+1 is taken from timing word bits [25:24]. No single correction moves a bit boundary by more than J+1 quanta.
- R5: A falling edge first seen in quantum q of the first segment (sync is quantum 0, so 1 <= q <= A+1) delays the sample strobe by min(q, J+1) quanta.
- R6: A falling edge first seen in quantum j of the second segment (0-based) makes that segment last max(j+1, (B+1) - min(B+1-j, J+1)) quanta.
- R7: A falling edge seen during the sync quantum has no effect. Rising edges have no effect on timing.
- R8: After one correction (normal or hard sync), any further edge in the same bit has no effect.
- R9: When `hard_sync_en` is 1, a falling edge on `rx_in` that changes just after clock edge E causes a `tx_point` pulse in the cycle after edge E+3. Quanta are counted again from that edge.
- R10: `sample_bit` takes the level of `rx_in` after it has passed the two-flop synchronizer, captured at the end of the first segment.
- R11: Timing word bits [31:30] are output unchanged on `mode_flags` and have no effect on timing.
- R12: During and right after reset, `seg_state` is 0, both strobes are low and `sample_bit` is 1 (recessive).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Received bus level (1 = recessive) |
| hard_sync_en | input | 1 | When 1, a falling edge restarts the bit |
| timing_cfg | input | 32 | Packed timing word |
| sample_strobe | output | 1 | One-cycle pulse at the sample point |
| sample_bit | output | 1 | Bus level captured at the last sample point |
| tx_point | output | 1 | One-cycle pulse at the start of each bit |
| seg_state | output | 2 | Current phase: 0 sync, 1 first segment, 2 second segment |
| mode_flags | output | 2 | Timing word bits [31:30], passed through |

## Verification
The assertions check, on every cycle, properties that involve only one or two cycles:
- the prescaler counts up in single steps;
- each strobe pulses only in the phase it belongs to;
- a stored correction never exceeds the jump width;
- the corrections stay frozen once the bit has used its one correction;
- the captured bit equals the synchronized level.

Only the bench scenarios can show the actual lengths of the quanta, segments and corrected bits for a given edge position. They also show the hard-sync latency and that the mode bits do not change timing. The bench measures these as cycle counts between strobes.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  localparam int BRP_W    = 10;
  localparam int TS1_W    = 4;
  localparam int TS2_W    = 3;
  localparam int SJW_W    = 2;
  localparam int BRP_LSB  = 0;
  localparam int TS1_LSB  = 16;
  localparam int TS2_LSB  = 20;
  localparam int SJW_LSB  = 24;
  localparam int MODE_LSB = 30;
  localparam int LEN1_W   = TS1_W + 1;
  localparam int LEN2_W   = TS2_W + 1;
  localparam int JMP_W    = SJW_W + 1;
  localparam int QCNT_W   = LEN1_W + 1;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PH1  = 2'd1,
    SEG_PH2  = 2'd2
  } seg_e;

  typedef struct packed {
    logic [BRP_W-1:0]  brp;
    logic [LEN1_W-1:0] len1;
    logic [LEN2_W-1:0] len2;
    logic [JMP_W-1:0]  jump;
  } timing_t;

  function automatic timing_t decode_timing(input logic [31:0] word);
    timing_t t;
    t.brp  = word[BRP_LSB +: BRP_W];
    t.len1 = LEN1_W'(word[TS1_LSB +: TS1_W]) + LEN1_W'(1);
    t.len2 = LEN2_W'(word[TS2_LSB +: TS2_W]) + LEN2_W'(1);
    t.jump = JMP_W'(word[SJW_LSB +: SJW_W]) + JMP_W'(1);
    return t;
  endfunction

  function automatic logic [JMP_W-1:0] clamp_jump(input logic [QCNT_W-1:0] err,
                                                  input logic [JMP_W-1:0]  lim);
    if (err > QCNT_W'(lim)) return lim;
    return err[JMP_W-1:0];
  endfunction
endpackage

// File: rtl/cbt_rx_sync.sv
module cbt_rx_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_in,
  output logic level,
  output logic fall
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= rx_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign level = sync_q;
  assign fall  = prev_q & ~sync_q;
endmodule

// File: rtl/cbt_prescaler.sv
module cbt_prescaler #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] brp,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap = (cnt_q >= brp);
  assign tick = wrap & ~restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (wrap)    cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  // R1: below the limit the count advances by exactly one per cycle
  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && cnt_q < brp) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/cbt_bit_fsm.sv
module cbt_bit_fsm
  import can_bt_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick,
  input  logic    fall,
  input  logic    level,
  input  logic    hard_sync_en,
  input  timing_t cfg,
  output logic    hs_fire,
  output seg_e    state,
  output logic    sample_strobe,
  output logic    sample_bit,
  output logic    tx_point
);
  seg_e              state_q, state_d;
  logic [QCNT_W-1:0] qcnt_q, qcnt_d;
  logic [JMP_W-1:0]  ext_q, shr_q, ext_now, shr_now;
  logic              used_q;
  logic              resync_ok, rs_ph1, rs_ph2;
  logic [QCNT_W-1:0] err1, err2, lim1, lim2;
  logic              ph1_done, ph2_done;

  assign resync_ok = fall & ~used_q;
  assign hs_fire   = resync_ok & hard_sync_en;
  assign rs_ph1    = resync_ok & ~hard_sync_en & (state_q == SEG_PH1);
  assign rs_ph2    = resync_ok & ~hard_sync_en & (state_q == SEG_PH2);

  assign err1    = qcnt_q + 1'b1;
  assign err2    = QCNT_W'(cfg.len2) - qcnt_q;
  assign ext_now = rs_ph1 ? clamp_jump(err1, cfg.jump) : ext_q;
  assign shr_now = rs_ph2 ? clamp_jump(err2, cfg.jump) : shr_q;
  assign lim1    = QCNT_W'(cfg.len1) + QCNT_W'(ext_now);
  assign lim2    = QCNT_W'(cfg.len2) - QCNT_W'(shr_now);

  assign ph1_done = tick & (state_q == SEG_PH1) & (qcnt_q + 1'b1 >= lim1);
  assign ph2_done = tick & (state_q == SEG_PH2) & (qcnt_q + 1'b1 >= lim2);

  always_comb begin
    state_d = state_q;
    qcnt_d  = qcnt_q;
    if (hs_fire) begin
      state_d = SEG_SYNC;
      qcnt_d  = '0;
    end else if (tick) begin
      case (state_q)
        SEG_SYNC: begin
          state_d = SEG_PH1;
          qcnt_d  = '0;
        end
        SEG_PH1: begin
          if (ph1_done) begin
            state_d = SEG_PH2;
            qcnt_d  = '0;
          end else qcnt_d = qcnt_q + 1'b1;
        end
        SEG_PH2: begin
          if (ph2_done) begin
            state_d = SEG_SYNC;
            qcnt_d  = '0;
          end else qcnt_d = qcnt_q + 1'b1;
        end
        default: begin
          state_d = SEG_SYNC;
          qcnt_d  = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= SEG_SYNC;
      qcnt_q        <= '0;
      ext_q         <= '0;
      shr_q         <= '0;
      used_q        <= 1'b0;
      sample_strobe <= 1'b0;
      sample_bit    <= 1'b1;
      tx_point      <= 1'b0;
    end else begin
      state_q       <= state_d;
      qcnt_q        <= qcnt_d;
      sample_strobe <= ph1_done;
      tx_point      <= hs_fire | ph2_done;
      if (ph1_done) sample_bit <= level;
      if (hs_fire || ph2_done) begin
        ext_q <= '0;
        shr_q <= '0;
      end else begin
        ext_q <= ext_now;
        shr_q <= shr_now;
      end
      if (hs_fire)              used_q <= 1'b1;
      else if (ph2_done)        used_q <= 1'b0;
      else if (rs_ph1 | rs_ph2) used_q <= 1'b1;
    end
  end

  assign state = state_q;

  // R2: the transmit point only ever marks the first cycle of a sync phase
  a_r2_tx_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
    tx_point |-> (state_q == SEG_SYNC && qcnt_q == '0));

  // R3: the sample strobe is seen only once the second segment has begun
  a_r3_sample_in_ph2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |-> (state_q == SEG_PH2));

  // R4: no stored correction exceeds the jump width
  a_r4_jump_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_q <= cfg.jump) && (shr_q <= cfg.jump));

  // R8: once the bit has used its correction, the corrections stay frozen until the bit ends
  a_r8_single_resync: assert property (@(posedge clk) disable iff (!rst_n)
    (used_q && !ph2_done) |=> ($stable(ext_q) && $stable(shr_q)));
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
  import can_bt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_in,
  input  logic        hard_sync_en,
  input  logic [31:0] timing_cfg,
  output logic        sample_strobe,
  output logic        sample_bit,
  output logic        tx_point,
  output logic [1:0]  seg_state,
  output logic [1:0]  mode_flags
);
  timing_t cfg;
  logic    rx_sync_lvl, rx_fall, tq_tick, hs_fire;
  seg_e    state;

  assign cfg        = decode_timing(timing_cfg);
  assign mode_flags = timing_cfg[MODE_LSB +: 2];
  assign seg_state  = state;

  cbt_rx_sync i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .rx_in (rx_in),
    .level (rx_sync_lvl),
    .fall  (rx_fall)
  );

  cbt_prescaler #(.CNT_W(BRP_W)) i_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (hs_fire),
    .brp     (cfg.brp),
    .tick    (tq_tick)
  );

  cbt_bit_fsm i_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick          (tq_tick),
    .fall          (rx_fall),
    .level         (rx_sync_lvl),
    .hard_sync_en  (hard_sync_en),
    .cfg           (cfg),
    .hs_fire       (hs_fire),
    .state         (state),
    .sample_strobe (sample_strobe),
    .sample_bit    (sample_bit),
    .tx_point      (tx_point)
  );

  // R10: the captured bit equals the synchronized level at the sample instant
  a_r10_sample_value: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |-> (sample_bit == $past(rx_sync_lvl)));
endmodule

// File: tb/test_can_bit_timer.sv
module test_can_bit_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_in = 1'b1;
  logic        hard_sync_en = 1'b0;
  logic [31:0] timing_cfg;
  logic        sample_strobe, sample_bit, tx_point;
  logic [1:0]  seg_state, mode_flags;
  int          checks = 0;
  int          fails = 0;

  can_bit_timer i_can_bit_timer (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .hard_sync_en(hard_sync_en),
    .timing_cfg(timing_cfg), .sample_strobe(sample_strobe), .sample_bit(sample_bit),
    .tx_point(tx_point), .seg_state(seg_state), .mode_flags(mode_flags)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mk_cfg(int p, int a, int b, int j, int m);
    logic [31:0] w = '0;
    w[9:0]   = 10'(p);
    w[19:16] = 4'(a);
    w[22:20] = 3'(b);
    w[25:24] = 2'(j);
    w[31:30] = 2'(m);
    return w;
  endfunction

  function automatic int min2(int x, int y);
    return (x < y) ? x : y;
  endfunction

  function automatic int exp_seg1(int n, int a, int j, int q);
    if (q == 0) return (a + 2) * n;
    return (a + 2 + min2(q, j + 1)) * n;
  endfunction

  function automatic int exp_bit_seg2(int n, int a, int b, int j, int k);
    int len2 = b + 1;
    int keep = len2 - min2(len2 - k, j + 1);
    int run  = (k + 1 > keep) ? k + 1 : keep;
    return (2 + a + run) * n;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic wait_tx();
    do @(negedge clk); while (!tx_point);
  endtask

  task automatic cnt_sample(output int c);
    c = 0;
    do begin @(negedge clk); c++; end while (!sample_strobe);
  endtask

  task automatic cnt_tx(output int c);
    c = 0;
    do begin @(negedge clk); c++; end while (!tx_point);
  endtask

  task automatic settle(logic [31:0] w);
    timing_cfg = w;
    rx_in = 1'b1;
    wait_tx();
    wait_tx();
  endtask

  task automatic run_seg1(int p, int a, int b, int j, int q);
    int n = p + 1;
    int k = q * n + 1;
    int c;
    settle(mk_cfg(p, a, b, j, 0));
    repeat (k) @(negedge clk);
    rx_in = 1'b0;
    cnt_sample(c);
    if (q == 0) chk(k + c == exp_seg1(n, a, j, q), "R7 sync-edge", k + c, exp_seg1(n, a, j, q));
    else        chk(k + c == exp_seg1(n, a, j, q), "R5 seg1 ext", k + c, exp_seg1(n, a, j, q));
    chk(sample_bit == 1'b0, "R10 sample_bit", int'(sample_bit), 0);
    rx_in = 1'b1;
  endtask

  task automatic run_seg2(int p, int a, int b, int j, int kq);
    int n = p + 1;
    int k = (2 + a + kq) * n + 1;
    int c;
    settle(mk_cfg(p, a, b, j, 0));
    repeat (k) @(negedge clk);
    rx_in = 1'b0;
    cnt_tx(c);
    chk(k + c == exp_bit_seg2(n, a, b, j, kq), "R6 seg2 shrink", k + c, exp_bit_seg2(n, a, b, j, kq));
    rx_in = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int c, c2, n;
    void'($urandom(32'd4711));
    timing_cfg = mk_cfg(5, 7, 2, 1, 0);
    repeat (3) @(negedge clk);
    chk(seg_state == 2'd0 && !tx_point && !sample_strobe && sample_bit,
        "R12 in reset", int'({seg_state, tx_point, sample_strobe, sample_bit}), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(seg_state == 2'd0 && !tx_point && !sample_strobe && sample_bit,
        "R12 after reset", int'({seg_state, tx_point, sample_strobe, sample_bit}), 1);

    // R1 R2 R3: nominal bit, N=6, A=7, B=2
    settle(mk_cfg(5, 7, 2, 1, 0));
    chk(seg_state == 2'd0, "R2 state at tx", int'(seg_state), 0);
    cnt_sample(c);
    chk(c == 9 * 6, "R3 tx to sample", c, 54);
    chk(seg_state == 2'd2, "R3 state at sample", int'(seg_state), 2);
    cnt_tx(c);
    chk(c == 3 * 6, "R3 sample to tx", c, 18);
    cnt_tx(c);
    chk(c == 12 * 6, "R1 R2 bit period", c, 72);

    // R2: shortest bit, one-cycle quantum
    settle(mk_cfg(0, 0, 0, 0, 0));
    cnt_tx(c);
    chk(c == 3, "R2 min bit", c, 3);
    cnt_sample(c);
    chk(c == 2, "R3 min tx to sample", c, 2);

    // R2: longest segments
    settle(mk_cfg(2, 15, 7, 3, 0));
    cnt_tx(c);
    chk(c == 25 * 3, "R2 max segs", c, 75);

    // R11: mode bits pass through without changing timing
    settle(mk_cfg(5, 7, 2, 1, 3));
    chk(mode_flags == 2'b11, "R11 flags", int'(mode_flags), 3);
    cnt_tx(c);
    chk(c == 72, "R11 timing unchanged", c, 72);

    // R7: rising edge inside seg1 has no effect
    n = 10;
    settle(mk_cfg(9, 5, 3, 3, 0));
    rx_in = 1'b0;
    wait_tx();
    rx_in = 1'b1;
    wait_tx();
    rx_in = 1'b0;
    repeat (3) wait_tx();
    repeat (2 * n + 1) @(negedge clk);
    rx_in = 1'b1;
    cnt_sample(c);
    chk(2 * n + 1 + c == 7 * n, "R7 rising edge", 2 * n + 1 + c, 7 * n);

    // R4 R5: edge deep in seg1 is clamped to J+1
    run_seg1(9, 8, 2, 0, 6);
    run_seg1(9, 8, 2, 3, 6);
    run_seg1(9, 5, 3, 3, 0);

    // R8: second edge in the same bit is ignored
    settle(mk_cfg(9, 8, 2, 3, 0));
    repeat (n + 1) @(negedge clk);
    rx_in = 1'b0;
    repeat (n) @(negedge clk);
    rx_in = 1'b1;
    repeat (n) @(negedge clk);
    rx_in = 1'b0;
    cnt_sample(c);
    chk(3 * n + 1 + c == 11 * n, "R8 second edge", 3 * n + 1 + c, 11 * n);
    rx_in = 1'b1;

    // R9 R10: hard sync latency and restart; R8 no further edge accepted
    settle(mk_cfg(9, 6, 2, 1, 0));
    hard_sync_en = 1'b1;
    repeat (2 * n + 1) @(negedge clk);
    rx_in = 1'b0;
    cnt_tx(c);
    chk(c == 3, "R9 hard sync latency", c, 3);
    repeat (n + 1) @(negedge clk);
    rx_in = 1'b1;
    repeat (n) @(negedge clk);
    rx_in = 1'b0;
    cnt_sample(c2);
    chk(2 * n + 1 + c2 == 8 * n, "R8 R9 after hard sync", 2 * n + 1 + c2, 8 * n);
    hard_sync_en = 1'b0;
    rx_in = 1'b1;

    // R6: directed seg2 edges
    run_seg2(9, 4, 7, 1, 0);
    run_seg2(9, 4, 7, 3, 6);
    run_seg2(9, 4, 2, 3, 1);

    // R5 R6: constrained random
    for (int i = 0; i < 20; i++) begin
      int p = $urandom_range(9, 4);
      int a = $urandom_range(15, 0);
      int b = $urandom_range(7, 0);
      int j = $urandom_range(3, 0);
      run_seg1(p, a, b, j, $urandom_range(a + 1, 1));
      run_seg2(p, a, b, j, $urandom_range(b, 0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule